// File: doc/BRIEF.md
# Sequential Address Bus Codec

This block sits on a parallel address bus and removes switching on the address wires when addresses arrive in order. The transmit half compares each incoming address with the previous one plus a fixed stride. On a match it leaves the address wires as they are and raises one extra increment wire. On a mismatch it puts the real address on the wires and keeps the increment wire low. The receive half keeps its own copy of the last address. It rebuilds each address either from that copy plus the stride or from the wires.

Both halves are in one module, so the encoded bus can be observed or routed between them. A long stream of in-order fetches therefore costs no toggles on the address wires. A branch or a jump costs one raw transfer. The stride and the address width are parameters. Stride arithmetic wraps modulo 2^ADDR_W.

Top module: `seq_addr_codec`

## Requirements
- R1: Each cycle with `in_vld`=1 produces one cycle later `bus_vld`=1 and `dec_vld`=1, and `dec_addr` equals the `in_addr` that was presented.
- R2: When an address equals the previous transferred address plus STRIDE, the bus cycle has `bus_inc`=1, `bus_addr` keeps the value of the prior cycle, and the decoder ignores `bus_addr` and rebuilds the address from its own copy.
- R3: When an address is not the successor, including a repeat of the same address, the bus cycle has `bus_inc`=0 and `bus_addr` equals that address.
- R4: The first transfer after reset is sent raw with `bus_inc`=0, even when it equals 0 plus STRIDE.
- R5: A run of consecutive in-stride addresses following a raw transfer causes zero bit changes on `bus_addr`.
- R6: The successor test wraps modulo 2^ADDR_W. With the defaults, 0xFFFC followed by 0x0000 is treated as sequential.
- R7: Idle cycles (`in_vld`=0) give `bus_vld`=0, leave `bus_addr` unchanged, and do not break a sequence: the next in-stride address after a gap is still sent with `bus_inc`=1.
- R8: During and immediately after reset, `bus_vld`=0, `dec_vld`=0, `bus_inc`=0 and `bus_addr`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Address on `in_addr` is a transfer this cycle |
| in_addr | input | ADDR_W | Address to be carried over the bus |
| bus_vld | output | 1 | Encoded bus holds a transfer |
| bus_addr | output | ADDR_W | Encoded address wires (frozen on sequential transfers) |
| bus_inc | output | 1 | 1: address is previous plus STRIDE; 0: raw address on wires |
| dec_vld | output | 1 | Decoded address valid |
| dec_addr | output | ADDR_W | Reconstructed address |

## Verification
The assertions rely on one assumption: the encoded bus produced by the transmit half reaches the receive half unaltered, so both halves see the same sequence of transfers. They also rely on `in_addr` carrying a defined value whenever `in_vld` is high. The stimulus drives the ports only at the falling clock edge and always drives a defined address. It mixes in-stride runs, deliberate idle gaps, repeats, a wrap at the top of the address space and random jumps. Because of this, the successor comparison is exercised on both outcomes, and the reset state is exercised before any traffic.

// File: rtl/seq_addr_codec.sv
module seq_addr_codec #(
  parameter int ADDR_W = 16,
  parameter int STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              bus_vld,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_inc,
  output logic              dec_vld,
  output logic [ADDR_W-1:0] dec_addr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

  logic [ADDR_W-1:0] tx_last, rx_last;
  logic              tx_primed, rx_primed;
  logic              tx_hit;

  assign tx_hit = tx_primed && (in_addr == tx_last + STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_vld   <= 1'b0;
      bus_addr  <= '0;
      bus_inc   <= 1'b0;
      tx_last   <= '0;
      tx_primed <= 1'b0;
    end else begin
      bus_vld <= in_vld;
      if (in_vld) begin
        bus_inc   <= tx_hit;
        tx_last   <= in_addr;
        tx_primed <= 1'b1;
        if (!tx_hit) bus_addr <= in_addr;
      end
    end
  end

  assign dec_vld  = bus_vld;
  assign dec_addr = bus_inc ? rx_last + STEP : bus_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_last   <= '0;
      rx_primed <= 1'b0;
    end else if (bus_vld) begin
      rx_last   <= dec_addr;
      rx_primed <= 1'b1;
    end
  end

  p_frozen_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vld && bus_inc |-> $stable(bus_addr));

  p_raw_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vld && !bus_inc |-> bus_addr == $past(in_addr));

  p_first_raw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vld && !rx_primed |-> !bus_inc);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_vld |-> $stable(bus_addr));

  p_mirror_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vld |=> rx_last == $past(tx_last));
endmodule

// File: tb/seq_addr_codec_tb.sv
module seq_addr_codec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int STR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [W-1:0] in_addr = '0;
  logic bus_vld, bus_inc, dec_vld;
  logic [W-1:0] bus_addr, dec_addr;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic pend_vld = 0, pend_inc = 0;
  logic [W-1:0] pend_addr = '0;
  logic [W-1:0] ref_last = '0;
  bit ref_primed = 0;
  logic [W-1:0] prev_bus = '0;
  int toggles = 0;

  seq_addr_codec #(.ADDR_W(W), .STRIDE(STR)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_addr(in_addr),
    .bus_vld(bus_vld), .bus_addr(bus_addr), .bus_inc(bus_inc),
    .dec_vld(dec_vld), .dec_addr(dec_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    toggles += $countones(bus_addr ^ prev_bus);
    chk("R1 bus_vld", W'(bus_vld), W'(pend_vld));
    chk("R1 dec_vld", W'(dec_vld), W'(pend_vld));
    if (pend_vld) begin
      chk("R1 dec_addr", dec_addr, pend_addr);
      chk("R2/R3 bus_inc", W'(bus_inc), W'(pend_inc));
      if (pend_inc) chk("R2 frozen bus_addr", bus_addr, prev_bus);
      else          chk("R3 raw bus_addr", bus_addr, pend_addr);
    end else begin
      chk("R7 idle bus_addr", bus_addr, prev_bus);
    end
    prev_bus = bus_addr;
  endtask

  task automatic cyc(input logic v, input logic [W-1:0] a);
    @(negedge clk);
    check_outputs();
    in_vld  = v;
    in_addr = a;
    pend_vld = v;
    if (v) begin
      pend_addr  = a;
      pend_inc   = ref_primed && (a == W'(ref_last + W'(STR)));
      ref_last   = a;
      ref_primed = 1;
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a;
    repeat (3) @(negedge clk);
    chk("R8 bus_vld in reset", W'(bus_vld), '0);
    chk("R8 dec_vld in reset", W'(dec_vld), '0);
    chk("R8 bus_inc in reset", W'(bus_inc), '0);
    chk("R8 bus_addr in reset", bus_addr, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 bus_vld after reset", W'(bus_vld), '0);
    chk("R8 bus_addr after reset", bus_addr, '0);
    // R4: 0x0004 would be successor of reset value 0, must go raw
    cyc(1, 16'h0004);
    cyc(0, '0);
    @(negedge clk);
    chk("R4 first transfer raw inc", W'(bus_inc), '0);
    chk("R4 first transfer raw addr", bus_addr, 16'h0004);
    // R5: sequential run, zero toggles
    toggles = 0;
    a = 16'h0008;
    for (int i = 0; i < 20; i++) begin cyc(1, a); a += STR; end
    cyc(0, '0);
    @(negedge clk);
    chk("R5 toggles during run", W'(toggles), '0);
    // R7: gaps inside a run
    cyc(1, 16'h1000);
    cyc(0, '0); cyc(0, '0);
    cyc(1, 16'h1004);
    cyc(0, '0);
    @(negedge clk);
    chk("R7 sequence kept across gap", W'(bus_inc), 16'h0001);
    // R3: repeat and non-stride step
    cyc(1, 16'h1004);
    cyc(1, 16'h1005);
    // R6: wrap
    cyc(1, 16'hFFF8); cyc(1, 16'hFFFC); cyc(1, 16'h0000); cyc(1, 16'h0004);
    cyc(0, '0);
    @(negedge clk);
    chk("R6 wrap kept frozen lines", bus_addr, 16'hFFF8);
    // random mix of runs and jumps
    a = 16'h2000;
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 60) begin a += STR; cyc(1, a); end
      else if (r < 75) cyc(0, W'($urandom));
      else begin a = W'($urandom); cyc(1, a); end
    end
    cyc(0, '0);
    cyc(0, '0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule